// File: doc/BRIEF.md
# Conditional Sum Adder

This block adds two unsigned N-bit operands and a single carry-in bit. It produces an N-bit sum and a carry-out, and it has no clock. Every bit position first forms a pair of candidate results. One candidate assumes no carry arrives at that bit. The other assumes a carry does arrive. Each candidate holds a sum bit and a carry bit.

Neighbouring groups are then combined level by level, and each level doubles the group size. At each level, the conditional carries of the lower group drive 2-way multiplexers that pick between the candidates of the upper group. Every merged group therefore still holds both candidates. The true carry-in is used only at the last step, where it picks the final sum and carry-out from the full-width pair. No carry ripples along the word.

The select path crosses one bit-cell stage, log2(N) merge levels and one final multiplexer. The width is a parameter and must be a power of two.

Top module: `cond_sum_adder`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 2^N for every input combination.
- R2: `carry_out` equals bit N of the (N+1)-bit value a + b + cin.
- R3: With both operands zero and `cin` = 0, `sum` is all zeros and `carry_out` is 0.
- R4: With both operands all ones and `cin` = 1, `sum` is all ones and `carry_out` is 1.
- R5: With `op_a` all ones, `op_b` zero and `cin` = 1, the carry crosses the whole word: `sum` is zero and `carry_out` is 1.
- R6: For every merged group, the candidate (carry, sum) that assumes an incoming carry equals the candidate that assumes none, plus one.
- R7: For every merged group, if the no-carry candidate carries out, then the with-carry candidate also carries out.
- R8: The width N is a power of two (default 16). R1 and R2 hold at N = 4 over all input values and at the default width.
- R9: Complementary alternating operands (0101... plus 1010...) give all ones with `carry_out` 0 when `cin` = 0, and give zero with `carry_out` 1 when `cin` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of op_a + op_b + cin |
| carry_out | output | 1 | Carry out of bit N-1 |

## Verification
The hardest case to reach is a carry that must cross every merge level. This happens when each group's choice depends on a carry-in that propagates through all the bits below it. Random operands seldom give a long run of propagate bits at 16 bits.

The bench therefore sweeps a 4-bit copy exhaustively, which covers every propagate and generate mix at every level. At the default width it adds vectors built to propagate across the whole word: all ones, complementary alternating bits and a single-bit generate at bit 0. Random operands follow these vectors.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Per-bit candidate pair: results with no incoming carry and with one.
    typedef struct packed {
        logic sum_nc;
        logic sum_wc;
        logic cy_nc;
        logic cy_wc;
    } bit_cand_t;

    // Builds the candidate pair for one bit position.
    function automatic bit_cand_t make_cand(input logic x, input logic y);
        bit_cand_t r;
        r.sum_nc = x ^ y;
        r.sum_wc = ~(x ^ y);
        r.cy_nc  = x & y;
        r.cy_wc  = x | y;
        return r;
    endfunction

    // Two-way select used at every merge point.
    function automatic logic pick(input logic sel, input logic when1, input logic when0);
        return sel ? when1 : when0;
    endfunction

endpackage

// File: rtl/csa_bit_cell.sv
module csa_bit_cell
    import csa_pkg::*;
(
    input  logic      x_i,
    input  logic      y_i,
    output bit_cand_t cand_o
);

    assign cand_o = make_cand(x_i, y_i);

endmodule

// File: rtl/csa_merge_level.sv
module csa_merge_level
    import csa_pkg::*;
#(
    parameter int N   = 16,
    parameter int GRP = 1
) (
    input  logic [N-1:0]         s_nc_i,
    input  logic [N-1:0]         s_wc_i,
    input  logic [N/GRP-1:0]     c_nc_i,
    input  logic [N/GRP-1:0]     c_wc_i,
    output logic [N-1:0]         s_nc_o,
    output logic [N-1:0]         s_wc_o,
    output logic [N/(2*GRP)-1:0] c_nc_o,
    output logic [N/(2*GRP)-1:0] c_wc_o
);

    localparam int NG_OUT = N / (2 * GRP);
    localparam int W2     = 2 * GRP;

    for (genvar k = 0; k < NG_OUT; k++) begin : g_grp
        localparam int LO = k * W2;
        localparam int HI = k * W2 + GRP;

        // Lower half already resolved for both assumptions.
        assign s_nc_o[LO +: GRP] = s_nc_i[LO +: GRP];
        assign s_wc_o[LO +: GRP] = s_wc_i[LO +: GRP];

        // Upper half picked by the lower group's conditional carries.
        for (genvar j = 0; j < GRP; j++) begin : g_bit
            assign s_nc_o[HI+j] = pick(c_nc_i[2*k], s_wc_i[HI+j], s_nc_i[HI+j]);
            assign s_wc_o[HI+j] = pick(c_wc_i[2*k], s_wc_i[HI+j], s_nc_i[HI+j]);
        end

        assign c_nc_o[k] = pick(c_nc_i[2*k], c_wc_i[2*k+1], c_nc_i[2*k+1]);
        assign c_wc_o[k] = pick(c_wc_i[2*k], c_wc_i[2*k+1], c_nc_i[2*k+1]);

        logic [W2:0] nc_plus1;
        always_comb begin
            nc_plus1 = {c_nc_o[k], s_nc_o[LO +: W2]} + {{W2{1'b0}}, 1'b1};
            if (!$isunknown({c_nc_o[k], c_wc_o[k], s_nc_o[LO +: W2], s_wc_o[LO +: W2]})) begin
                AST_WC_IS_NC_PLUS_ONE: assert ({c_wc_o[k], s_wc_o[LO +: W2]} == nc_plus1); // R6
                AST_CARRY_ORDER: assert (!c_nc_o[k] || c_wc_o[k]); // R7
            end
        end
    end

endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder
    import csa_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         carry_out
);

    localparam int LOG_N = $clog2(N);

    initial begin
        AST_WIDTH_POW2: assert (N >= 2 && N == (1 << LOG_N)); // R8
    end

    for (genvar L = 0; L <= LOG_N; L++) begin : lvl
        logic [N-1:0]        s_nc;
        logic [N-1:0]        s_wc;
        logic [(N>>L)-1:0]   c_nc;
        logic [(N>>L)-1:0]   c_wc;

        if (L == 0) begin : g_cells
            for (genvar i = 0; i < N; i++) begin : g_bit
                bit_cand_t cand;
                csa_bit_cell u_cell (
                    .x_i    (op_a[i]),
                    .y_i    (op_b[i]),
                    .cand_o (cand)
                );
                assign s_nc[i] = cand.sum_nc;
                assign s_wc[i] = cand.sum_wc;
                assign c_nc[i] = cand.cy_nc;
                assign c_wc[i] = cand.cy_wc;
            end
        end else begin : g_merge
            csa_merge_level #(
                .N   (N),
                .GRP (1 << (L - 1))
            ) u_merge (
                .s_nc_i (lvl[L-1].s_nc),
                .s_wc_i (lvl[L-1].s_wc),
                .c_nc_i (lvl[L-1].c_nc),
                .c_wc_i (lvl[L-1].c_wc),
                .s_nc_o (s_nc),
                .s_wc_o (s_wc),
                .c_nc_o (c_nc),
                .c_wc_o (c_wc)
            );
        end
    end

    // Final step: the real carry-in resolves the full-width pair.
    assign sum       = cin ? lvl[LOG_N].s_wc : lvl[LOG_N].s_nc;
    assign carry_out = pick(cin, lvl[LOG_N].c_wc[0], lvl[LOG_N].c_nc[0]);

    logic [N:0] ref_total;
    always_comb begin
        ref_total = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, cin};
        if (!$isunknown({op_a, op_b, cin, sum, carry_out})) begin
            AST_SUM_EXACT: assert (sum == ref_total[N-1:0]); // R1
            AST_CARRY_EXACT: assert (carry_out == ref_total[N]); // R2
        end
    end

endmodule

// File: tb/cond_sum_adder_tb.sv
`timescale 1ns/1ps
module cond_sum_adder_tb;

    localparam int NB = 16;
    localparam int NS = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [NB-1:0] a, b, s;
    logic          ci, co;
    logic [NS-1:0] a4, b4, s4;
    logic          ci4, co4;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    cond_sum_adder #(.N(NB)) u_dut (
        .op_a(a), .op_b(b), .cin(ci), .sum(s), .carry_out(co)
    );

    cond_sum_adder #(.N(NS)) u_dut4 (
        .op_a(a4), .op_b(b4), .cin(ci4), .sum(s4), .carry_out(co4)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic apply16(input logic [NB-1:0] x, input logic [NB-1:0] y, input logic c,
                           input string req);
        logic [NB:0] tot;
        @(negedge clk);
        a = x; b = y; ci = c;
        #1;
        tot = {1'b0, x} + {1'b0, y} + {{NB{1'b0}}, c};
        check({req, " sum"}, 64'(s), 64'(tot[NB-1:0]));
        check({req, " carry"}, 64'(co), 64'(tot[NB]));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        a4 = '0; b4 = '0; ci4 = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        // R3: zero operands give zero outputs
        check("R3 zero sum", 64'(s), 64'd0);
        check("R3 zero carry", 64'(co), 64'd0);

        // R8: exhaustive sweep of the 4-bit configuration (R1, R2)
        for (int ai = 0; ai < 16; ai++) begin
            for (int bi = 0; bi < 16; bi++) begin
                for (int c = 0; c < 2; c++) begin
                    int tot;
                    @(negedge clk);
                    a4 = 4'(ai); b4 = 4'(bi); ci4 = 1'(c);
                    #1;
                    tot = ai + bi + c;
                    check("R8 R1 n4 sum", 64'(s4), 64'(tot % 16));
                    check("R8 R2 n4 carry", 64'(co4), 64'(tot / 16));
                end
            end
        end

        // R4: all ones plus all ones plus one
        apply16('1, '1, 1'b1, "R4");
        check("R4 sum ones", 64'(s), 64'hFFFF);
        check("R4 carry set", 64'(co), 64'd1);

        // R5: full-length propagate string
        apply16('1, '0, 1'b1, "R5");
        check("R5 sum zero", 64'(s), 64'd0);
        check("R5 carry set", 64'(co), 64'd1);

        // R9: complementary alternating operands
        apply16(16'h5555, 16'hAAAA, 1'b0, "R9 cin0");
        check("R9 cin0 sum", 64'(s), 64'hFFFF);
        check("R9 cin0 carry", 64'(co), 64'd0);
        apply16(16'hAAAA, 16'h5555, 1'b1, "R9 cin1");
        check("R9 cin1 sum", 64'(s), 64'd0);
        check("R9 cin1 carry", 64'(co), 64'd1);

        // Single generate at bit 0 rippling through propagate bits (R1, R2)
        apply16(16'hFFFF, 16'h0001, 1'b0, "R1 R2 gen0");
        apply16(16'h7FFF, 16'h0001, 1'b0, "R1 R2 msb");
        apply16(16'h0000, 16'h0000, 1'b1, "R1 R2 cin only");

        // Random operands at the default width (R1, R2)
        for (int i = 0; i < 3000; i++) begin
            apply16(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 rand");
        end

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule